// File: doc/BRIEF.md
# Cyclic Prefix Inserter for Multitone Symbols

This block sits right after the inverse transform of a multitone transmitter. It receives real time-domain samples one symbol at a time. For each symbol it sends a guard interval first, then the symbol. The guard interval is a copy of the symbol's final samples, and it lets the receiver treat the channel as circular.

The guard is built from the tail of the symbol but is sent ahead of it. The whole symbol must therefore be stored before the first output sample can leave. Two symbol buffers take turns, so one symbol is written while the one before it is read out. Both sides use valid/ready streaming. Output samples carry a start marker and an end marker.

Parameters set the symbol length and the guard length. The guard is normally one sixteenth of the symbol:
- 512 samples with a 32-sample guard gives 544 output samples per symbol.
- 64 samples with a 4-sample guard gives 68 output samples per symbol.

Samples are 16-bit two's complement and pass through unscaled.

Top module: `cp_inserter`

## Requirements
- R1: While reset is high and in the first cycle after reset, `m_valid` is 0. In that first cycle `s_ready` is 1.
- R2: For each input symbol x[0..N-1], the output is exactly N+G samples, in this order: x[N-G..N-1], then x[0..N-1]. Values are unchanged. Symbols leave in arrival order.
- R3: `m_sos` is 1 only on the first guard sample (x[N-G]). `m_eos` is 1 only on the last symbol sample (x[N-1]).
- R4: No sample of a symbol is output before its last input sample is accepted. When the output is idle, `m_valid` rises in the second cycle after that acceptance.
- R5: While one symbol is being output, the next symbol's samples are accepted (`s_ready` is 1 when the first guard sample is presented).
- R6: When both buffers hold symbols not yet released, `s_ready` is 0. No sample is dropped or duplicated under any back-pressure.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data`, `m_sos` and `m_eos` hold their values.
- R8: With `m_ready` held at 1, a symbol's N+G samples leave on consecutive cycles: its end marker comes exactly N+G-1 cycles after its start marker.
- R9: A buffer can be filled and the other buffer released in the same cycle. Both symbols still come out complete and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample is valid |
| s_ready | output | 1 | Block can take an input sample |
| s_data | input | DATA_W | Input time-domain sample, two's complement |
| m_valid | output | 1 | Output sample is valid |
| m_ready | input | 1 | Consumer takes the output sample |
| m_data | output | DATA_W | Output sample |
| m_sos | output | 1 | First sample of the guard interval |
| m_eos | output | 1 | Last sample of the symbol |

## Verification
Two events can land on the same clock edge:
- the writer accepting the final sample of one buffer, which marks that buffer full;
- the reader issuing the final sample of the other buffer, which frees it.

The bench provokes this by sending one symbol at full rate with `m_ready` held high. It then idles the input for exactly G cycles, so that the next symbol's last sample meets the reader's last issue. The run is judged at the ports: both symbols must come out complete and in order, with correct markers, and the input must keep flowing afterwards.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  // Read phase: guard copy from the symbol tail, then the symbol body.
  typedef enum logic {
    PH_PREFIX = 1'b0,
    PH_BODY   = 1'b1
  } cpi_phase_e;

  function automatic int cpi_frame_len(input int sym_len, input int cp_len);
    return sym_len + cp_len;
  endfunction

endpackage

// File: rtl/cpi_ram.sv
// Two symbol banks in one array; the bank is the address MSB.
// The read data register doubles as the output data register.
module cpi_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW:0]       waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW:0]       raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** (AW + 1);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cpi_wr_ctrl.sv
// Write sequencer: walks the sample index and swaps banks at symbol end.
module cpi_wr_ctrl #(
  parameter int SYM_LEN = 64,
  parameter int AW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  output logic          bank,
  output logic [AW-1:0] idx,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(SYM_LEN - 1);

  assign done = accept && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      bank <= 1'b0;
    end else if (accept) begin
      if (idx == LAST) begin
        idx  <= '0;
        bank <= ~bank;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpi_rd_seq.sv
// Read sequencer: guard phase walks the tail indices, body phase walks
// the full symbol, then the bank is released and the reader swaps.
module cpi_rd_seq
  import cpi_pkg::*;
#(
  parameter int SYM_LEN = 64,
  parameter int CP_LEN  = 4,
  parameter int AW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  output logic          bank,
  output logic [AW-1:0] idx,
  output logic          sos,
  output logic          eos,
  output logic          done
);
  localparam logic [AW-1:0] START = AW'(SYM_LEN - CP_LEN);
  localparam logic [AW-1:0] LAST  = AW'(SYM_LEN - 1);

  cpi_phase_e phase;

  assign sos  = (phase == PH_PREFIX) && (idx == START);
  assign eos  = (phase == PH_BODY) && (idx == LAST);
  assign done = issue && eos;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_PREFIX;
      idx   <= START;
      bank  <= 1'b0;
    end else if (issue) begin
      if (idx == LAST) begin
        if (phase == PH_PREFIX) begin
          phase <= PH_BODY;
          idx   <= '0;
        end else begin
          phase <= PH_PREFIX;
          idx   <= START;
          bank  <= ~bank;
        end
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cp_inserter.sv
module cp_inserter
  import cpi_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SYM_LEN = 64,
  parameter int CP_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sos,
  output logic              m_eos
);
  localparam int AW        = (SYM_LEN > 1) ? $clog2(SYM_LEN) : 1;
  localparam int FRAME_LEN = cpi_frame_len(SYM_LEN, CP_LEN);

  generate
    if (CP_LEN < 1 || CP_LEN > SYM_LEN || FRAME_LEN < 2) begin : g_bad_cfg
      $error("cp_inserter: CP_LEN must be in 1..SYM_LEN");
    end
  endgenerate

  logic [1:0]    full_q;
  logic          wr_bank, rd_bank;
  logic [AW-1:0] wr_idx, rd_idx;
  logic          wr_done, rd_done;
  logic          rd_sos, rd_eos;
  logic          accept, issue;

  assign s_ready = ~full_q[wr_bank];
  assign accept  = s_valid && s_ready;
  assign issue   = full_q[rd_bank] && (!m_valid || m_ready);

  cpi_wr_ctrl #(.SYM_LEN(SYM_LEN), .AW(AW)) wr_i (
    .clk(clk), .rst(rst), .accept(accept),
    .bank(wr_bank), .idx(wr_idx), .done(wr_done)
  );

  cpi_rd_seq #(.SYM_LEN(SYM_LEN), .CP_LEN(CP_LEN), .AW(AW)) rd_i (
    .clk(clk), .rst(rst), .issue(issue),
    .bank(rd_bank), .idx(rd_idx), .sos(rd_sos), .eos(rd_eos), .done(rd_done)
  );

  cpi_ram #(.DATA_W(DATA_W), .AW(AW)) ram_i (
    .clk(clk),
    .we(accept), .waddr({wr_bank, wr_idx}), .wdata(s_data),
    .re(issue), .raddr({rd_bank, rd_idx}), .rdata(m_data)
  );

  // Set and clear always target different banks: the writer's bank
  // is empty when it completes, the reader's bank is full when it ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 2'b00;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (wr_done && (wr_bank == b[0]))      full_q[b] <= 1'b1;
        else if (rd_done && (rd_bank == b[0])) full_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_sos   <= 1'b0;
      m_eos   <= 1'b0;
    end else if (issue) begin
      m_valid <= 1'b1;
      m_sos   <= rd_sos;
      m_eos   <= rd_eos;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cpi_checker.sv
module cpi_checker #(
  parameter int DATA_W  = 16,
  parameter int SYM_LEN = 64,
  parameter int CP_LEN  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_sos,
  input logic              m_eos
);
  localparam int FRAME = SYM_LEN + CP_LEN;

  int unsigned in_pos, out_pos, in_syms, out_syms;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pos <= 0; out_pos <= 0; in_syms <= 0; out_syms <= 0;
    end else begin
      if (s_valid && s_ready) begin
        if (in_pos == SYM_LEN - 1) begin
          in_pos  <= 0;
          in_syms <= in_syms + 1;
        end else begin
          in_pos <= in_pos + 1;
        end
      end
      if (m_valid && m_ready) begin
        if (m_eos) begin
          out_pos  <= 0;
          out_syms <= out_syms + 1;
        end else begin
          out_pos <= out_pos + 1;
        end
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> !m_valid);

  assert_sos_pos_R3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_sos) |-> (out_pos == 0));

  assert_eos_pos_R3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_eos) |-> (out_pos == FRAME - 1));

  assert_whole_symbol_R4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_sos) |-> (in_syms > out_syms));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |-> (in_syms - out_syms <= 2));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sos) && $stable(m_eos)));
endmodule

bind cp_inserter cpi_checker #(
  .DATA_W(DATA_W), .SYM_LEN(SYM_LEN), .CP_LEN(CP_LEN)
) chk_i (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_sos(m_sos), .m_eos(m_eos)
);

// File: tb/cp_inserter_tb_top.sv
`timescale 1ns/1ps
module cp_inserter_tb_top;
  localparam int DW    = 16;
  localparam int SYM   = 64;
  localparam int CP    = 4;
  localparam int FRAME = SYM + CP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [DW-1:0] m_data;
  logic          m_sos, m_eos;

  always #4 clk = ~clk;

  cp_inserter #(.DATA_W(DW), .SYM_LEN(SYM), .CP_LEN(CP)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sos(m_sos), .m_eos(m_eos)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rmode = 0;       // 0: always ready, 1: never ready, 2: random
  bit span_on = 0;
  bit r5_arm = 0;
  bit done_flag = 0;
  int sos_cyc = 0;
  logic [DW+1:0] exp_q[$];
  logic          hold_prev = 0;
  logic [DW+1:0] hold_val = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rmode)
        0: m_ready = 1'b1;
        1: m_ready = 1'b0;
        default: m_ready = ($urandom % 3) != 0;
      endcase
    end
  end

  // Output monitor: compares every handshake with the expected stream.
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev) begin
        check(m_valid && ({m_sos, m_eos, m_data} == hold_val), "R7", "held beat",
              {m_sos, m_eos, m_data}, hold_val);
      end
      hold_prev = m_valid && !m_ready;
      hold_val  = {m_sos, m_eos, m_data};
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected beat (duplicate)", m_data, 0);
        end else begin
          logic [DW+1:0] e;
          e = exp_q.pop_front();
          check({m_sos, m_eos, m_data} == e, "R2", "beat {sos,eos,data}",
                {m_sos, m_eos, m_data}, e);
        end
        if (m_sos) begin
          sos_cyc = cyc;
          if (r5_arm) begin
            check(s_ready == 1'b1, "R5", "s_ready during output", s_ready, 1);
            r5_arm = 0;
          end
        end
        if (m_eos && span_on)
          check(cyc - sos_cyc == FRAME - 1, "R8", "sos-to-eos span", cyc - sos_cyc, FRAME - 1);
      end
    end
  end

  task automatic make_sym(input int seed, output logic [DW-1:0] s[SYM]);
    for (int i = 0; i < SYM; i++) s[i] = DW'(seed * 977 + i * 131) ^ DW'(i << 9);
    for (int i = SYM - CP; i < SYM; i++)
      exp_q.push_back({(i == SYM - CP), 1'b0, s[i]});
    for (int i = 0; i < SYM; i++)
      exp_q.push_back({1'b0, (i == SYM - 1), s[i]});
  endtask

  task automatic push(input logic [DW-1:0] d);
    s_valid = 1'b1;
    s_data  = d;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic send_symbol(input int seed, input bit gaps);
    logic [DW-1:0] s[SYM];
    make_sym(seed, s);
    for (int i = 0; i < SYM; i++) begin
      if (gaps && ($urandom % 4 == 0)) repeat ($urandom % 3 + 1) @(posedge clk);
      if (gaps) #1;
      push(s[i]);
    end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || m_valid) && n < 5000) begin
      @(posedge clk); n++;
    end
    #1;
    check(exp_q.size() == 0, req, "samples still missing", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
    check(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
  endtask

  task automatic t_single_latency();
    logic [DW-1:0] s[SYM];
    rmode = 0;
    make_sym(11, s);
    @(posedge clk); #1;
    for (int i = 0; i < SYM - 1; i++) push(s[i]);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(m_valid == 1'b0, "R4", "output before last input", m_valid, 0);
    @(posedge clk); #1;
    push(s[SYM - 1]);
    @(negedge clk);
    check(m_valid == 1'b0, "R4", "m_valid one cycle after last input", m_valid, 0);
    @(negedge clk);
    check(m_valid && m_sos, "R4", "first guard two cycles after last input",
          {m_valid, m_sos}, 3);
    check(m_data == s[SYM - CP], "R3", "first guard value", m_data, s[SYM - CP]);
    drain("R2");
  endtask

  task automatic t_stream();
    rmode = 0; span_on = 1; r5_arm = 1;
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) send_symbol(20 + k, 0);
    drain("R2");
    span_on = 0;
    check(r5_arm == 0, "R5", "first guard observed", r5_arm, 0);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] held;
    rmode = 1;
    @(posedge clk); #1;
    send_symbol(40, 0);
    send_symbol(41, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(s_ready == 1'b0, "R6", "s_ready with both buffers full", s_ready, 0);
    check(m_valid && m_sos, "R3", "stalled first guard", {m_valid, m_sos}, 3);
    held = m_data;
    fork
      send_symbol(42, 0);
      begin
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(s_ready == 1'b0, "R6", "s_ready still low", s_ready, 0);
        check(m_data == held, "R7", "data held under stall", m_data, held);
        rmode = 2;
      end
    join
    drain("R6");
  endtask

  task automatic t_random();
    rmode = 2;
    @(posedge clk); #1;
    for (int k = 0; k < 5; k++) send_symbol(60 + k, 1);
    drain("R2");
  endtask

  task automatic t_simultaneous();
    rmode = 0;
    @(posedge clk); #1;
    send_symbol(80, 0);
    repeat (CP) @(posedge clk);
    #1;
    send_symbol(81, 0);
    send_symbol(82, 0);
    drain("R9");
    @(negedge clk);
    check(s_ready == 1'b1 && m_valid == 1'b0, "R9", "idle after same-cycle fill/release",
          {s_ready, m_valid}, 2);
  endtask

  initial begin
    t_reset();
    t_single_latency();
    t_stream();
    t_backpressure();
    t_random();
    t_simultaneous();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule